// File: doc/BRIEF.md
# Per-Sector ECC Result Aggregator

The aggregator sits behind a page ECC decoder and folds the per-sector decode results of one flash page into a single page summary word and an error interrupt. A page is divided into 512-byte sectors; the page size code picks how many sectors (one to eight) make up the page. The decoder delivers one result strobe per sector, in sector order, carrying a decoder-fail bit, a corrected bit and the number of bits it corrected. The aggregator also compares that count against the selected correction strength and treats a sector whose count is beyond the strength as failed.

A page begins with a start pulse that clears the running bitmaps and the running maximum and captures the page size and strength codes. When the strobe of the last sector arrives, the summary word is latched and a one-cycle done pulse is produced. The interrupt is raised if any sector of the page needed correction or failed, and it stays set until it is cleared by a write-one-to-clear strobe. Only a single maximum correction count is kept for the whole page, not a count per sector.

Top module: `ecc_sector_aggregator`

## Requirements
- R1: Bit 24+i of `status_o` is set when sector i of the page failed, either because `res_fail_i` was high or because `res_nbits_i` exceeded the selected strength.
- R2: `strength_i` codes 0, 1, 2, 3 select strengths of 4, 8, 14 and 16 bits; a count equal to the strength is not a failure, one above it is.
- R3: Bit 16+i of `status_o` is set when sector i did not fail and `res_corr_i` was high; a sector never has both its fail and corrected bits set.
- R4: Bits 12:8 of `status_o` hold the largest `res_nbits_i` among sectors that did not fail (zero if none); failed sectors do not contribute, and bits 15:13 and 7:0 are zero.
- R5: `page_size_i` codes 0, 1, 2, 3 give pages of 1, 2, 4 and 8 sectors; `status_o` is latched at the clock edge of the last sector's strobe and does not change on any other edge.
- R6: `page_start_i` clears the running bitmaps and maximum and restarts at sector 0, also in the middle of a page; it wins over a strobe in the same cycle, and strobes outside a page are ignored.
- R7: `irq_o` is set at the summary latch when any fail or corrected bit of the new summary is set; a page in which every sector is clean leaves it unchanged.
- R8: `irq_o` is cleared by `irq_clr_i`, holds otherwise, and a set at the same edge as a clear wins.
- R9: `page_done_o` is high for exactly the one cycle after the last sector's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_start_i | input | 1 | Starts a new page, captures size and strength |
| page_size_i | input | 2 | Page size code: 1, 2, 4 or 8 sectors |
| strength_i | input | 2 | Strength code: 4, 8, 14 or 16 bits |
| res_valid_i | input | 1 | Sector result strobe |
| res_fail_i | input | 1 | Decoder could not correct the sector |
| res_corr_i | input | 1 | Decoder corrected bits in the sector |
| res_nbits_i | input | 5 | Number of bits corrected in the sector |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt |
| status_o | output | 32 | Latched page summary word |
| page_done_o | output | 1 | One-cycle pulse after the summary latch |
| irq_o | output | 1 | Combined page error interrupt |

## Verification
The assertions watch on every cycle that the fail and corrected bitmaps never overlap, that the summary word only moves together with the done pulse, that the done pulse lasts one cycle, and that the interrupt rises only at a summary latch and obeys its clear and hold rules. Whether the bitmaps land on the right sector indices, whether the strength threshold sits exactly at 4, 8, 14 and 16, and whether failed sectors are kept out of the maximum can only be shown by the bench's pages, which compare each summary against a model. The same holds for page restarts in mid-page, strobes outside a page and each page size code.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
  localparam int unsigned SEC_MAX  = 8;
  localparam int unsigned CNT_W    = 5;
  localparam int unsigned SIZE_W   = 2;
  localparam int unsigned IDX_W    = $clog2(SEC_MAX);
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned FAIL_LSB = 24;
  localparam int unsigned CORR_LSB = 16;
  localparam int unsigned MAX_LSB  = 8;

  typedef enum logic [1:0] {
    STR_4  = 2'd0,
    STR_8  = 2'd1,
    STR_14 = 2'd2,
    STR_16 = 2'd3
  } strength_e;

  function automatic logic [CNT_W-1:0] strength_limit(strength_e s);
    case (s)
      STR_4:   return CNT_W'(4);
      STR_8:   return CNT_W'(8);
      STR_14:  return CNT_W'(14);
      default: return CNT_W'(16);
    endcase
  endfunction

  // last sector index for a page size code: 2^code sectors
  function automatic logic [IDX_W-1:0] last_index(logic [SIZE_W-1:0] code);
    logic [IDX_W:0] n;
    n = (IDX_W+1)'(1) << code;
    return IDX_W'(n - 1'b1);
  endfunction
endpackage

// File: rtl/ecc_sector_classify.sv
module ecc_sector_classify
  import ecc_agg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         dec_fail_i,
  input  logic         dec_corr_i,
  input  logic [W-1:0] nbits_i,
  input  logic [W-1:0] limit_i,
  output logic         sec_fail_o,
  output logic         sec_corr_o,
  output logic [W-1:0] sec_cnt_o
);
  logic over;

  always_comb begin
    over       = nbits_i > limit_i;
    sec_fail_o = dec_fail_i | over;
    sec_corr_o = dec_corr_i & ~sec_fail_o;
    // failed sectors do not feed the maximum
    sec_cnt_o  = sec_fail_o ? '0 : nbits_i;
  end
endmodule

// File: rtl/ecc_sector_accum.sv
module ecc_sector_accum
  import ecc_agg_pkg::*;
#(
  parameter int unsigned N = SEC_MAX,
  parameter int unsigned W = CNT_W,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] last_idx_i,
  input  logic          strobe_i,
  input  logic          sec_fail_i,
  input  logic          sec_corr_i,
  input  logic [W-1:0]  sec_cnt_i,
  output logic [N-1:0]  fail_nxt_o,
  output logic [N-1:0]  corr_nxt_o,
  output logic [W-1:0]  max_nxt_o,
  output logic          last_hit_o
);
  logic          active_q;
  logic [IW-1:0] idx_q, last_q;
  logic [N-1:0]  fail_q, corr_q;
  logic [W-1:0]  max_q;
  logic          hit;

  assign hit        = strobe_i & active_q & ~start_i;
  assign last_hit_o = hit & (idx_q == last_q);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sel;
    assign sel           = hit & (idx_q == IW'(i));
    assign fail_nxt_o[i] = fail_q[i] | (sel & sec_fail_i);
    assign corr_nxt_o[i] = corr_q[i] | (sel & sec_corr_i);
  end

  assign max_nxt_o = (hit && sec_cnt_i > max_q) ? sec_cnt_i : max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      fail_q   <= '0;
      corr_q   <= '0;
      max_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      last_q   <= last_idx_i;
      fail_q   <= '0;
      corr_q   <= '0;
      max_q    <= '0;
    end else if (hit) begin
      fail_q <= fail_nxt_o;
      corr_q <= corr_nxt_o;
      max_q  <= max_nxt_o;
      idx_q  <= idx_q + 1'b1;
      if (last_hit_o) active_q <= 1'b0;
    end
  end

  p_no_stray_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> $stable(fail_q) || $past(start_i));
  p_idx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> idx_q <= last_q);
endmodule

// File: rtl/ecc_agg_irq.sv
module ecc_agg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !irq_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
endmodule

// File: rtl/ecc_sector_aggregator.sv
module ecc_sector_aggregator
  import ecc_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_start_i,
  input  logic [SIZE_W-1:0] page_size_i,
  input  logic [1:0]        strength_i,
  input  logic              res_valid_i,
  input  logic              res_fail_i,
  input  logic              res_corr_i,
  input  logic [CNT_W-1:0]  res_nbits_i,
  input  logic              irq_clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              page_done_o,
  output logic              irq_o
);
  strength_e         str_q;
  logic [CNT_W-1:0]  limit;
  logic              sec_fail, sec_corr;
  logic [CNT_W-1:0]  sec_cnt;
  logic [SEC_MAX-1:0] fail_nxt, corr_nxt;
  logic [CNT_W-1:0]  max_nxt;
  logic              last_hit, err_set;
  logic [STAT_W-1:0] status_q, status_nxt;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           str_q <= STR_4;
    else if (page_start_i) str_q <= strength_e'(strength_i);
  end

  assign limit = strength_limit(str_q);

  ecc_sector_classify #(.W(CNT_W)) u_classify (
    .dec_fail_i (res_fail_i),
    .dec_corr_i (res_corr_i),
    .nbits_i    (res_nbits_i),
    .limit_i    (limit),
    .sec_fail_o (sec_fail),
    .sec_corr_o (sec_corr),
    .sec_cnt_o  (sec_cnt)
  );

  ecc_sector_accum #(.N(SEC_MAX), .W(CNT_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (page_start_i),
    .last_idx_i (last_index(page_size_i)),
    .strobe_i   (res_valid_i),
    .sec_fail_i (sec_fail),
    .sec_corr_i (sec_corr),
    .sec_cnt_i  (sec_cnt),
    .fail_nxt_o (fail_nxt),
    .corr_nxt_o (corr_nxt),
    .max_nxt_o  (max_nxt),
    .last_hit_o (last_hit)
  );

  always_comb begin
    status_nxt = '0;
    status_nxt[FAIL_LSB +: SEC_MAX] = fail_nxt;
    status_nxt[CORR_LSB +: SEC_MAX] = corr_nxt;
    status_nxt[MAX_LSB  +: CNT_W]   = max_nxt;
  end

  assign err_set = last_hit & (|fail_nxt | |corr_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_hit;
      if (last_hit) status_q <= status_nxt;
    end
  end

  ecc_agg_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  assign status_o    = status_q;
  assign page_done_o = done_q;

  p_disjoint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[FAIL_LSB +: SEC_MAX] & status_o[CORR_LSB +: SEC_MAX]) == '0);
  p_latch_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_done_o |-> $stable(status_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_done_o |=> !page_done_o);
  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> page_done_o);
endmodule

// File: tb/ecc_sector_aggregator_tb.sv
module ecc_sector_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_start = 1'b0;
  logic [1:0]  page_size = '0;
  logic [1:0]  strength = '0;
  logic        res_valid = 1'b0;
  logic        res_fail = 1'b0;
  logic        res_corr = 1'b0;
  logic [4:0]  res_nbits = '0;
  logic        irq_clr = 1'b0;
  logic [31:0] status;
  logic        page_done;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic       sf [8];
  logic       sc [8];
  logic [4:0] sn [8];
  logic       exp_irq = 1'b0;

  always #5 clk = ~clk;

  ecc_sector_aggregator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .page_start_i(page_start), .page_size_i(page_size),
    .strength_i(strength), .res_valid_i(res_valid), .res_fail_i(res_fail),
    .res_corr_i(res_corr), .res_nbits_i(res_nbits), .irq_clr_i(irq_clr),
    .status_o(status), .page_done_o(page_done), .irq_o(irq)
  );

  function automatic int lim_of(logic [1:0] s);
    case (s) 2'd0: return 4; 2'd1: return 8; 2'd2: return 14; default: return 16; endcase
  endfunction

  function automatic logic [31:0] model(logic [1:0] psz, logic [1:0] s);
    logic [7:0] f, c;
    logic [4:0] m;
    f = '0; c = '0; m = '0;
    for (int i = 0; i < (1 << psz); i++) begin
      logic bad;
      bad = sf[i] || (int'(sn[i]) > lim_of(s));
      f[i] = bad;
      c[i] = !bad && sc[i];
      if (!bad && sn[i] > m) m = sn[i];
    end
    return {f, c, 3'b000, m, 8'h00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic start(logic [1:0] psz, logic [1:0] s);
    @(negedge clk);
    page_start = 1'b1; page_size = psz; strength = s;
    @(negedge clk);
    page_start = 1'b0; page_size = $urandom; strength = $urandom;
  endtask

  task automatic strobe(logic f, logic c, logic [4:0] n, logic clr);
    @(negedge clk);
    res_valid = 1'b1; res_fail = f; res_corr = c; res_nbits = n; irq_clr = clr;
    @(negedge clk);
    res_valid = 1'b0; irq_clr = 1'b0;
  endtask

  // runs a whole page from sf/sc/sn and checks R1-type results at the end
  task automatic page(logic [1:0] psz, logic [1:0] s, logic clr_last, string req);
    logic [31:0] prev, exp;
    int n;
    n = 1 << psz;
    exp = model(psz, s);
    start(psz, s);
    prev = status;
    for (int i = 0; i < n; i++) begin
      strobe(sf[i], sc[i], sn[i], clr_last && (i == n - 1));
      if (i < n - 1) begin
        check("R5 status stable mid-page", status, prev);
        check("R9 no done mid-page", {31'b0, page_done}, 32'd0);
      end
    end
    check(req, status, exp);
    check("R9 done pulse", {31'b0, page_done}, 32'd1);
    if (exp[31:16] != 0) exp_irq = 1'b1;
    else if (clr_last) exp_irq = 1'b0;
    check("R7 irq after page", {31'b0, irq}, {31'b0, exp_irq});
    @(negedge clk);
    check("R9 done falls", {31'b0, page_done}, 32'd0);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    exp_irq = 1'b0;
    check("R8 irq cleared", {31'b0, irq}, 32'd0);
  endtask

  task automatic clean();
    for (int i = 0; i < 8; i++) begin sf[i] = 0; sc[i] = 0; sn[i] = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset status", status, 32'd0);
    check("R7 reset irq", {31'b0, irq}, 32'd0);
    check("R9 reset done", {31'b0, page_done}, 32'd0);

    // R6: strobes before any page are ignored
    strobe(1'b1, 1'b0, 5'd3, 1'b0);
    check("R6 stray strobe status", status, 32'd0);
    check("R6 stray strobe done", {31'b0, page_done}, 32'd0);

    // R7: clean 8-sector page leaves irq clear
    clean();
    page(2'd3, 2'd1, 1'b0, "R7 clean page status");

    // R1/R3/R4 directed: sector 2 fails by decoder, sector 5 corrected 7 bits
    clean();
    sf[2] = 1; sn[2] = 5'd31; sc[5] = 1; sn[5] = 5'd7; sc[1] = 1; sn[1] = 5'd3;
    page(2'd3, 2'd3, 1'b0, "R1 R3 R4 directed map");
    clear_irq();
    @(negedge clk);
    check("R8 irq holds clear", {31'b0, irq}, 32'd0);

    // R2 boundaries for every strength code
    for (int s = 0; s < 4; s++) begin
      clean();
      sc[0] = 1; sn[0] = 5'(lim_of(2'(s)));
      sc[1] = 1; sn[1] = 5'(lim_of(2'(s)) + 1);
      page(2'd1, 2'(s), 1'b0, "R2 strength threshold");
    end

    // R8: set wins over clear at the same edge; irq currently set
    clean();
    sc[0] = 1; sn[0] = 5'd2;
    page(2'd0, 2'd0, 1'b1, "R8 set beats clear");
    // clean page with clear on last strobe: irq clears, status all zero
    clean();
    page(2'd0, 2'd0, 1'b1, "R8 clear on clean page");

    // R6: restart in mid-page discards earlier sectors
    start(2'd3, 2'd0);
    strobe(1'b1, 1'b0, 5'd0, 1'b0);
    strobe(1'b1, 1'b0, 5'd0, 1'b0);
    clean();
    sc[1] = 1; sn[1] = 5'd1;
    page(2'd1, 2'd0, 1'b0, "R6 restart mid-page");
    // R6: start wins over a same-cycle strobe
    @(negedge clk);
    page_start = 1'b1; page_size = 2'd0; strength = 2'd0;
    res_valid = 1'b1; res_fail = 1'b1; res_nbits = 5'd0;
    @(negedge clk);
    page_start = 1'b0; res_valid = 1'b0; res_fail = 1'b0;
    check("R6 start beats strobe: no done", {31'b0, page_done}, 32'd0);
    strobe(1'b0, 1'b0, 5'd0, 1'b0);
    check("R6 start beats strobe: status", status, 32'd0);
    check("R5 one-sector page done", {31'b0, page_done}, 32'd1);
    clear_irq();

    // R1-R5 random pages
    for (int p = 0; p < 60; p++) begin
      logic [1:0] psz, s;
      psz = 2'($urandom_range(0, 3));
      s   = 2'($urandom_range(0, 3));
      for (int i = 0; i < 8; i++) begin
        sf[i] = ($urandom_range(0, 7) == 0);
        sn[i] = ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom_range(0, 20));
        sc[i] = (sn[i] != 0);
      end
      if ($urandom_range(0, 3) == 0) clean();
      page(psz, s, 1'b0, "R1 R3 R4 R5 random page");
      if ($urandom_range(0, 1) == 1) clear_irq();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule